// File: doc/BRIEF.md
# Strobed BCD Readout Demultiplexer

This block sits behind a 3½-digit dual-slope converter whose result leaves the chip as one shared 4-bit BCD bus and a set of one-hot slot strobes. Slot 0 carries a status nibble. The remaining slots carry the full decimal digits, from the most significant down. The block samples the bus into a per-slot shadow register whenever that slot's strobe is high. It then copies the whole shadow set into the display registers in one step on the rising edge of the end-of-conversion pulse, so a frame is never shown half old and half new.

From the committed status nibble the block derives the leading "1", the sign, and the overrange and underrange flags. It drives active-high seven-segment vectors for each full digit, a half-digit vector that can only light segments b and c, and separate plus and minus indicators. An overrange reading flashes the whole readout in time with a slow blink input. An underrange reading only raises its flag.

Top module: `bcd_display_demux`

## Requirements
- R1: While `strobe_i[s]` is high at a rising clock edge, slot s's shadow register takes `bcd_i`. A strobe held high over several edges keeps the last value sampled.
- R2: Display registers load all slots' shadow values together at the edge where `eoc_i` is high and was low at the previous edge. They hold at every other edge, including while `eoc_i` stays high.
- R3: Segment vectors are ordered {g,f,e,d,c,b,a} with a in bit 0, and a 1 lights the segment. Full digit k (`seg_full_o[7k+6:7k]`) shows the committed value of slot k+1 with these hex patterns for 0..9: 3F 06 5B 4F 66 6D 7D 07 7F 6F.
- R4: A full-digit code from 10 to 15 gives an all-zero segment vector.
- R5: With status bit 3 low, `seg_half_o` is 7'h06 (segments b and c only), whatever the other status bits are. With bit 3 high it is 0.
- R6: With status bit 2 high, `plus_o`=1 and `minus_o`=0. With bit 2 low, the reverse.
- R7: Status bit 0 high with bit 3 low sets `over_o`. While `over_o` is set and `blink_i` is low, all segment vectors, `plus_o` and `minus_o` are 0. With `blink_i` high the readout shows normally.
- R8: Status bit 0 high with bit 3 high sets `under_o`. It does not blank the readout. `over_o` and `under_o` are never both set.
- R9: After reset the readout shows positive 000 with the half digit dark: each full digit 7'h3F, `seg_half_o`=0, `plus_o`=1, `minus_o`=0, both flags 0.
- R10: Bus values present while a slot's strobe is low do not change that slot's shadow register, so they never reach the display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bcd_i | input | 4 | Shared multiplexed BCD/status bus |
| strobe_i | input | NUM_FULL+1 | Slot strobes; bit 0 status, bit k+1 full digit k |
| eoc_i | input | 1 | End-of-conversion pulse; rising edge commits a frame |
| blink_i | input | 1 | Slow flash clock used during overrange |
| seg_full_o | output | 7*NUM_FULL | Segment vectors of the full digits, digit k in bits 7k+6:7k |
| seg_half_o | output | 7 | Half-digit segment vector (b, c only) |
| plus_o | output | 1 | Positive sign indicator |
| minus_o | output | 1 | Negative sign indicator |
| over_o | output | 1 | Overrange flag |
| under_o | output | 1 | Underrange flag |

## Verification
The hardest case to reach is an end-of-conversion level that stays high while strobes keep refreshing the shadow registers. A design that commits on the level instead of the edge looks correct whenever the pulse is one cycle wide. The bench holds `eoc_i` high across several strobe loads and confirms the readout stays frozen until a fresh rising edge. It also holds a strobe high while the bus changes, then moves the bus with all strobes low, to separate the "last sample wins" rule from the "ignored when low" rule.

// File: rtl/bcd_disp_pkg.sv
package bcd_disp_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // bit order {g,f,e,d,c,b,a}
  localparam seg_t SEG_BC   = 7'h06;
  localparam bcd_t STAT_RST = 4'b1100;  // half dark, positive, in range

  function automatic seg_t bcd_to_seg(bcd_t v);
    seg_t s;
    case (v)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/slot_latch.sv
module slot_latch
  import bcd_disp_pkg::*;
#(
  parameter bcd_t RST_VAL = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic commit_i,
  input  bcd_t d_i,
  output bcd_t shadow_o,
  output bcd_t q_o
);
  bcd_t shadow_q, disp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RST_VAL;
      disp_q   <= RST_VAL;
    end else begin
      if (cap_i)    shadow_q <= d_i;
      if (commit_i) disp_q   <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign q_o      = disp_q;
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import bcd_disp_pkg::*;
(
  input  bcd_t bcd_i,
  output seg_t seg_o
);
  assign seg_o = bcd_to_seg(bcd_i);
endmodule

// File: rtl/status_decode.sv
module status_decode
  import bcd_disp_pkg::*;
(
  input  bcd_t stat_i,
  output logic half_one_o,
  output logic positive_o,
  output logic over_o,
  output logic under_o
);
  logic unused_stat;
  assign unused_stat = stat_i[1];

  assign half_one_o = ~stat_i[3];
  assign positive_o = stat_i[2];
  assign over_o     = stat_i[0] & ~stat_i[3];
  assign under_o    = stat_i[0] &  stat_i[3];
endmodule

// File: rtl/bcd_display_demux.sv
module bcd_display_demux
  import bcd_disp_pkg::*;
#(
  parameter int NUM_FULL = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [BCD_W-1:0]          bcd_i,
  input  logic [NUM_FULL:0]         strobe_i,
  input  logic                      eoc_i,
  input  logic                      blink_i,
  output logic [SEG_W*NUM_FULL-1:0] seg_full_o,
  output logic [SEG_W-1:0]          seg_half_o,
  output logic                      plus_o,
  output logic                      minus_o,
  output logic                      over_o,
  output logic                      under_o
);
  localparam int NUM_SLOTS = NUM_FULL + 1;

  logic eoc_q;
  logic commit;
  logic [NUM_SLOTS-1:0][BCD_W-1:0] slot_sh;
  logic [NUM_SLOTS-1:0][BCD_W-1:0] slot_q;
  logic [NUM_FULL-1:0][SEG_W-1:0]  raw_full;
  logic half_one, positive, over_raw, under_raw, blank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eoc_q <= 1'b0;
    else         eoc_q <= eoc_i;
  end

  assign commit = eoc_i & ~eoc_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    slot_latch #(
      .RST_VAL((s == 0) ? STAT_RST : bcd_t'(0))
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cap_i   (strobe_i[s]),
      .commit_i(commit),
      .d_i     (bcd_i),
      .shadow_o(slot_sh[s]),
      .q_o     (slot_q[s])
    );
  end

  for (genvar k = 0; k < NUM_FULL; k++) begin : g_dec
    seg_decoder u_dec (
      .bcd_i(slot_q[k+1]),
      .seg_o(raw_full[k])
    );
  end

  status_decode u_stat (
    .stat_i    (slot_q[0]),
    .half_one_o(half_one),
    .positive_o(positive),
    .over_o    (over_raw),
    .under_o   (under_raw)
  );

  // overrange flashes the whole readout
  assign blank = over_raw & ~blink_i;

  assign seg_full_o = blank ? '0 : raw_full;
  assign seg_half_o = (!blank && half_one) ? SEG_BC : '0;
  assign plus_o     = !blank &&  positive;
  assign minus_o    = !blank && !positive;
  assign over_o     = over_raw;
  assign under_o    = under_raw;
endmodule

// File: rtl/bcd_display_demux_chk.sv
module bcd_display_demux_chk
  import bcd_disp_pkg::*;
#(
  parameter int NUM_FULL = 3
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic [BCD_W-1:0]                    bcd_i,
  input logic [NUM_FULL:0]                   strobe_i,
  input logic                                eoc_i,
  input logic                                blink_i,
  input logic [NUM_FULL:0][BCD_W-1:0]        slot_sh,
  input logic [NUM_FULL:0][BCD_W-1:0]        slot_q,
  input logic [SEG_W*NUM_FULL-1:0]           seg_full_o,
  input logic [SEG_W-1:0]                    seg_half_o,
  input logic                                plus_o,
  input logic                                minus_o,
  input logic                                over_o,
  input logic                                under_o
);
  logic eoc_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eoc_prev <= 1'b0;
    else         eoc_prev <= eoc_i;
  end

  for (genvar s = 0; s <= NUM_FULL; s++) begin : g_s
    p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i[s] |=> slot_sh[s] == $past(bcd_i));
    p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strobe_i[s] |=> $stable(slot_sh[s]));
    p_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoc_i && !eoc_prev) |=> slot_q[s] == $past(slot_sh[s]));
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(eoc_i && !eoc_prev) |=> $stable(slot_q[s]));
  end

  for (genvar k = 0; k < NUM_FULL; k++) begin : g_k
    p_blank_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_q[k+1] > 4'd9) |-> seg_full_o[SEG_W*k +: SEG_W] == '0);
  end

  p_half_bc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_half_o & ~SEG_BC) == '0);
  p_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({plus_o, minus_o}) && (!(over_o && !blink_i) -> (plus_o ^ minus_o)));
  p_flash_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_o && !blink_i) |-> (seg_full_o == '0 && seg_half_o == '0 && !plus_o && !minus_o));
  p_flag_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(over_o && under_o));
endmodule

bind bcd_display_demux bcd_display_demux_chk #(.NUM_FULL(NUM_FULL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bcd_i     (bcd_i),
  .strobe_i  (strobe_i),
  .eoc_i     (eoc_i),
  .blink_i   (blink_i),
  .slot_sh   (slot_sh),
  .slot_q    (slot_q),
  .seg_full_o(seg_full_o),
  .seg_half_o(seg_half_o),
  .plus_o    (plus_o),
  .minus_o   (minus_o),
  .over_o    (over_o),
  .under_o   (under_o)
);

// File: tb/tb_bcd_display_demux.sv
`timescale 1ns/1ps
module tb_bcd_display_demux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bcd = '0;
  logic [3:0]  strobe = '0;
  logic        eoc = 1'b0;
  logic        blink = 1'b1;
  logic [20:0] seg_full;
  logic [6:0]  seg_half;
  logic        plus, minus, over, under;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bcd_display_demux dut (
    .clk_i(clk), .rst_ni(rst_n), .bcd_i(bcd), .strobe_i(strobe),
    .eoc_i(eoc), .blink_i(blink), .seg_full_o(seg_full), .seg_half_o(seg_half),
    .plus_o(plus), .minus_o(minus), .over_o(over), .under_o(under)
  );

  function automatic logic [6:0] exp_seg(logic [3:0] v);
    case (v)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_slot(int s, logic [3:0] v);
    @(negedge clk); bcd = v; strobe = 4'b0001 << s;
    @(negedge clk); strobe = '0;
  endtask

  task automatic pulse_eoc();
    @(negedge clk); eoc = 1'b1;
    @(negedge clk); eoc = 1'b0;
  endtask

  task automatic frame(logic [3:0] st, logic [3:0] d0, logic [3:0] d1, logic [3:0] d2);
    load_slot(0, st); load_slot(1, d0); load_slot(2, d1); load_slot(3, d2);
    pulse_eoc();
  endtask

  function automatic logic [20:0] full_of(logic [3:0] d0, logic [3:0] d1, logic [3:0] d2);
    return {exp_seg(d2), exp_seg(d1), exp_seg(d0)};
  endfunction

  task automatic t_reset_r9();
    chk("R9 full", 32'(seg_full), 32'(full_of(0, 0, 0)));
    chk("R9 half", 32'(seg_half), 0);
    chk("R9 sign", {30'd0, plus, minus}, 2'b10);
    chk("R9 flags", {30'd0, over, under}, 2'b00);
  endtask

  task automatic t_digits_r3();
    for (int b = 0; b < 10; b += 3) begin
      frame(4'b1100, 4'(b), 4'((b + 1) % 10), 4'((b + 2) % 10));
      chk("R3 digits", 32'(seg_full), 32'(full_of(4'(b), 4'((b + 1) % 10), 4'((b + 2) % 10))));
    end
  endtask

  task automatic t_bad_codes_r4();
    frame(4'b1100, 4'd10, 4'd12, 4'd15);
    chk("R4 blank 10/12/15", 32'(seg_full), 0);
    frame(4'b1100, 4'd11, 4'd8, 4'd14);
    chk("R4 mixed", 32'(seg_full), 32'(full_of(4'd11, 4'd8, 4'd14)));
  endtask

  task automatic t_half_r5();
    for (int i = 0; i < 8; i++) begin
      logic [3:0] st;
      st = {i[2], i[1], i[0], 1'b0};
      frame(st, 4'd5, 4'd5, 4'd5);
      chk("R5 half", 32'(seg_half), st[3] ? 0 : 32'h06);
    end
  endtask

  task automatic t_polarity_r6();
    frame(4'b0100, 4'd1, 4'd2, 4'd3);
    chk("R6 positive", {30'd0, plus, minus}, 2'b10);
    frame(4'b0000, 4'd1, 4'd2, 4'd3);
    chk("R6 negative", {30'd0, plus, minus}, 2'b01);
  endtask

  task automatic t_over_r7();
    frame(4'b0001, 4'd9, 4'd9, 4'd9);
    blink = 1'b1; #1;
    chk("R7 flag", {30'd0, over, under}, 2'b10);
    chk("R7 shown full", 32'(seg_full), 32'(full_of(9, 9, 9)));
    chk("R7 shown half", 32'(seg_half), 32'h06);
    chk("R7 shown sign", {30'd0, plus, minus}, 2'b01);
    blink = 1'b0; #1;
    chk("R7 dark full", 32'(seg_full), 0);
    chk("R7 dark half+sign", {24'd0, seg_half, plus, minus}, 0);
    chk("R7 flag kept", 32'(over), 1);
    blink = 1'b1; #1;
    chk("R7 back", 32'(seg_full), 32'(full_of(9, 9, 9)));
  endtask

  task automatic t_under_r8();
    blink = 1'b0;
    frame(4'b1101, 4'd0, 4'd1, 4'd7);
    chk("R8 flag", {30'd0, over, under}, 2'b01);
    chk("R8 no flash", 32'(seg_full), 32'(full_of(0, 1, 7)));
    chk("R8 sign", {30'd0, plus, minus}, 2'b10);
    blink = 1'b1;
  endtask

  task automatic t_hold_r2();
    frame(4'b1100, 4'd1, 4'd2, 4'd3);
    load_slot(1, 4'd7); load_slot(2, 4'd8);
    chk("R2 no eoc hold", 32'(seg_full), 32'(full_of(1, 2, 3)));
    @(negedge clk); eoc = 1'b1;
    @(negedge clk);
    chk("R2 edge commit", 32'(seg_full), 32'(full_of(7, 8, 3)));
    load_slot(3, 4'd6); load_slot(0, 4'b0000);
    chk("R2 level hold", 32'(seg_full), 32'(full_of(7, 8, 3)));
    chk("R2 level hold sign", {30'd0, plus, minus}, 2'b10);
    @(negedge clk); eoc = 1'b0;
    @(negedge clk);
    chk("R2 fall hold", 32'(seg_full), 32'(full_of(7, 8, 3)));
    pulse_eoc();
    chk("R2 next edge", 32'(seg_full), 32'(full_of(7, 8, 6)));
    chk("R2 next edge sign", {30'd0, plus, minus}, 2'b01);
  endtask

  task automatic t_capture_r1_r10();
    @(negedge clk); strobe = 4'b0010; bcd = 4'd1;
    @(negedge clk); bcd = 4'd4;
    @(negedge clk); bcd = 4'd7;
    @(negedge clk); strobe = '0; bcd = 4'd3;
    @(negedge clk); bcd = 4'd2;
    @(negedge clk); bcd = 4'd5;
    pulse_eoc();
    chk("R1 last sample wins", 32'(seg_full[6:0]), 32'(exp_seg(4'd7)));
    chk("R10 low strobe ignored", 32'(seg_full[20:7]), 32'({exp_seg(4'd6), exp_seg(4'd8)}));
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r9();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r9();
    t_digits_r3();
    t_bad_codes_r4();
    t_half_r5();
    t_polarity_r6();
    t_over_r7();
    t_under_r8();
    t_hold_r2();
    t_capture_r1_r10();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule